// File: doc/BRIEF.md
# Bypassable Pixel Clock Divider

This block turns a fast reference clock into a pixel-rate clock enable. Software writes a shared timing register. This block picks three things out of that word: a divisor code split into two fields that are not next to each other, and a bypass flag. The divisor is the joined code plus two. When the bypass flag is set, the enable is high on every reference cycle.

Downstream logic stays on the reference clock and advances one pixel on each cycle where `pix_en` is high. A toggled square wave, `pix_clk`, is also provided for driving a panel pin. It comes from a register, so it has no glitches. A new divisor is taken only at the end of a period. Rewriting the register mid-frame therefore never produces a short period or a short pulse.

Top module: `pclk_divider`

## Requirements
- R1: The divisor code is 10 bits. Its low five bits are register bits [4:0], and its high five bits are register bits [31:27], placed directly above the low bits. With bypass clear, `pix_en` is high for one cycle out of every (code + 2) cycles.
- R2: When register bit 26 (bypass) is set, `pix_en` is high on every cycle, whatever the code fields hold.
- R3: Register bits [25:5] have no effect on either output.
- R4: A register change made partway through a period does not alter that period. The current period completes at its old length, and the new divisor applies from the following period.
- R5: The all-ones code gives the largest divisor, 1025 cycles.
- R6: For a divisor D of at least 2, `pix_clk` is high during the last floor(D/2) cycles of each period and low during the first ceil(D/2) cycles. For odd D, the high phase is therefore one cycle shorter than the low phase.
- R7: In bypass, `pix_clk` is held low.
- R8: While reset is asserted, both outputs are low. The first clock edge after reset samples the register and starts a period at count zero. The first `pix_en` is high in the D-th cycle after release, so no enable appears before a full period has elapsed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_word | input | 32 | Timing register value that holds the code fields and the bypass flag |
| pix_en | output | 1 | One-cycle pixel enable at the end of each period |
| pix_clk | output | 1 | Registered toggled pixel clock |

## Verification
The assertions assume that `cfg_word` is stable around each rising edge. Software may write any value at any time, so the bench changes `cfg_word` only at falling edges. It never restricts the values it writes: noise bits, all-ones codes and bypass with junk code fields are all allowed. The properties inside the counter assume that a divisor is loaded only at a period boundary. The bench deliberately rewrites the register mid-period to exercise this assumption.

// File: rtl/pclk_div_pkg.sv
package pclk_div_pkg;
  localparam int REG_W   = 32;
  localparam int LO_LSB  = 0;
  localparam int LO_W    = 5;
  localparam int HI_LSB  = 27;
  localparam int HI_W    = 5;
  localparam int BYP_BIT = 26;
  localparam int CODE_W  = LO_W + HI_W;
  localparam int CNT_W   = CODE_W + 1;
  localparam int MAX_DIV = (1 << CODE_W) + 1;

  typedef logic [CODE_W-1:0] code_t;
  typedef logic [CNT_W-1:0]  cnt_t;

  // Divisor from a code and the bypass flag: bypass means divide-by-one.
  function automatic cnt_t code_to_div(input code_t c, input logic byp);
    cnt_t d;
    if (byp) d = cnt_t'(1);
    else     d = cnt_t'(c) + cnt_t'(2);
    return d;
  endfunction

  // High phase covers the tail of the period: the last floor(div/2) counts.
  function automatic logic in_high_phase(input cnt_t cnt, input cnt_t div);
    logic h;
    if (div < cnt_t'(2)) h = 1'b0;
    else                 h = (cnt >= (div - (div >> 1)));
    return h;
  endfunction
endpackage

// File: rtl/pclk_field_decode.sv
module pclk_field_decode
  import pclk_div_pkg::*;
#(
  parameter int P_REG_W   = REG_W,
  parameter int P_LO_LSB  = LO_LSB,
  parameter int P_LO_W    = LO_W,
  parameter int P_HI_LSB  = HI_LSB,
  parameter int P_HI_W    = HI_W,
  parameter int P_BYP_BIT = BYP_BIT,
  localparam int L_CODE_W = P_LO_W + P_HI_W,
  localparam int L_CNT_W  = L_CODE_W + 1
) (
  input  logic [P_REG_W-1:0]  cfg_word,
  output logic [L_CODE_W-1:0] code,
  output logic                bypass,
  output logic [L_CNT_W-1:0]  divisor
);
  // Low field lands at the bottom of the code.
  for (genvar i = 0; i < P_LO_W; i++) begin : g_lo
    assign code[i] = cfg_word[P_LO_LSB + i];
  end
  // High field is shifted down to sit directly above the low field.
  for (genvar j = 0; j < P_HI_W; j++) begin : g_hi
    assign code[P_LO_W + j] = cfg_word[P_HI_LSB + j];
  end

  assign bypass  = cfg_word[P_BYP_BIT];
  assign divisor = code_to_div(code, bypass);
endmodule

// File: rtl/pclk_period_ctr.sv
module pclk_period_ctr
  import pclk_div_pkg::*;
#(
  parameter int P_CNT_W = CNT_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [P_CNT_W-1:0] next_div,
  output logic               started,
  output logic [P_CNT_W-1:0] cnt,
  output logic [P_CNT_W-1:0] div_q,
  output logic               period_end,
  output logic [P_CNT_W-1:0] cnt_nx,
  output logic [P_CNT_W-1:0] div_nx
);
  logic load_now;

  always_comb begin
    period_end = started && (cnt == (div_q - P_CNT_W'(1)));
    load_now   = !started || period_end;
    if (load_now) begin
      cnt_nx = '0;
      div_nx = next_div;
    end else begin
      cnt_nx = cnt + P_CNT_W'(1);
      div_nx = div_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      started <= 1'b0;
      cnt     <= '0;
      div_q   <= '0;
    end else begin
      started <= 1'b1;
      cnt     <= cnt_nx;
      div_q   <= div_nx;
    end
  end

  a_r1_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    started |-> (cnt < div_q));

  a_r1_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
    period_end |=> (cnt == '0));

  a_r1_load_sampled: assert property (@(posedge clk) disable iff (!rst_n)
    load_now |=> (div_q == $past(next_div)));

  a_r4_div_held_mid_period: assert property (@(posedge clk) disable iff (!rst_n)
    (started && !period_end) |=> $stable(div_q));

  a_r8_first_period_from_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(started) |-> (cnt == '0));
endmodule

// File: rtl/pclk_phase_gen.sv
module pclk_phase_gen
  import pclk_div_pkg::*;
#(
  parameter int P_CNT_W = CNT_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [P_CNT_W-1:0] cnt_nx,
  input  logic [P_CNT_W-1:0] div_nx,
  output logic               pix_clk
);
  logic high_nx;
  assign high_nx = in_high_phase(cnt_t'(cnt_nx), cnt_t'(div_nx));

  // Registered so the panel pin never sees a decode glitch.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pix_clk <= 1'b0;
    else        pix_clk <= high_nx;
  end

  a_r6_low_at_period_start: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_nx == '0 && div_nx > P_CNT_W'(1)) |=> !pix_clk);
endmodule

// File: rtl/pclk_divider.sv
module pclk_divider
  import pclk_div_pkg::*;
#(
  parameter int P_REG_W   = REG_W,
  parameter int P_LO_LSB  = LO_LSB,
  parameter int P_LO_W    = LO_W,
  parameter int P_HI_LSB  = HI_LSB,
  parameter int P_HI_W    = HI_W,
  parameter int P_BYP_BIT = BYP_BIT,
  localparam int L_CODE_W = P_LO_W + P_HI_W,
  localparam int L_CNT_W  = L_CODE_W + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [P_REG_W-1:0] cfg_word,
  output logic               pix_en,
  output logic               pix_clk
);
  logic [L_CODE_W-1:0] code_w;
  logic                bypass_w;
  logic [L_CNT_W-1:0]  next_div_w;
  logic                started_w;
  logic [L_CNT_W-1:0]  cnt_w;
  logic [L_CNT_W-1:0]  div_q_w;
  logic                period_end_w;
  logic [L_CNT_W-1:0]  cnt_nx_w;
  logic [L_CNT_W-1:0]  div_nx_w;

  pclk_field_decode #(
    .P_REG_W(P_REG_W), .P_LO_LSB(P_LO_LSB), .P_LO_W(P_LO_W),
    .P_HI_LSB(P_HI_LSB), .P_HI_W(P_HI_W), .P_BYP_BIT(P_BYP_BIT)
  ) u_decode (
    .cfg_word(cfg_word),
    .code    (code_w),
    .bypass  (bypass_w),
    .divisor (next_div_w)
  );

  pclk_period_ctr #(.P_CNT_W(L_CNT_W)) u_ctr (
    .clk       (clk),
    .rst_n     (rst_n),
    .next_div  (next_div_w),
    .started   (started_w),
    .cnt       (cnt_w),
    .div_q     (div_q_w),
    .period_end(period_end_w),
    .cnt_nx    (cnt_nx_w),
    .div_nx    (div_nx_w)
  );

  pclk_phase_gen #(.P_CNT_W(L_CNT_W)) u_phase (
    .clk    (clk),
    .rst_n  (rst_n),
    .cnt_nx (cnt_nx_w),
    .div_nx (div_nx_w),
    .pix_clk(pix_clk)
  );

  assign pix_en = period_end_w;

  a_r8_quiet_before_start: assert property (@(posedge clk) disable iff (!rst_n)
    !started_w |-> (!pix_en && !pix_clk));

  a_r6_high_on_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_en && div_q_w > L_CNT_W'(1)) |-> pix_clk);

  a_r7_bypass_clock_low: assert property (@(posedge clk) disable iff (!rst_n)
    (started_w && div_q_w == L_CNT_W'(1)) |-> !pix_clk);

  a_r2_bypass_every_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (started_w && div_q_w == L_CNT_W'(1)) |-> pix_en);
endmodule

// File: tb/pclk_divider_tb.sv
module pclk_divider_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] cfg_word = 32'h0;
  logic        pix_en;
  logic        pix_clk;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // Behavioural model state
  bit m_started = 1'b0;
  int m_cnt = 0;
  int m_div = 0;

  // Observation bookkeeping
  int since_en = 0;
  int last_gap = -1;
  int hi_run = 0;
  int last_hi = -1;
  bit prev_clk = 1'b0;

  always #5 clk = ~clk;

  pclk_divider dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_word(cfg_word),
    .pix_en(pix_en), .pix_clk(pix_clk)
  );

  function automatic int div_of(input logic [31:0] w);
    int lo = int'(w & 32'h1f);
    int hi = int'((w >> 27) & 32'h1f);
    if (w[26]) return 1;
    return hi * 32 + lo + 2;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp_v);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
    end
  endtask

  task automatic model_step(input logic [31:0] w);
    if (!m_started || m_cnt == m_div - 1) begin
      m_started = 1'b1;
      m_cnt = 0;
      m_div = div_of(w);
    end else begin
      m_cnt++;
    end
  endtask

  // One cycle: compare at the falling edge, then present stimulus for next rise.
  task automatic cyc(input logic [31:0] nv, input string req);
    bit e_en, e_clk;
    @(negedge clk);
    e_en  = m_started && (m_cnt == m_div - 1);
    e_clk = m_started && (m_div >= 2) && (m_cnt >= m_div - m_div / 2);
    check(pix_en == e_en, {req, " pix_en"}, int'(pix_en), int'(e_en));
    check(pix_clk == e_clk, {req, " pix_clk"}, int'(pix_clk), int'(e_clk));
    since_en++;
    if (pix_en) begin last_gap = since_en; since_en = 0; end
    if (pix_clk) hi_run++;
    else if (prev_clk) begin last_hi = hi_run; hi_run = 0; end
    prev_clk = pix_clk;
    cfg_word = nv;
    if (rst_n) model_step(nv);
  endtask

  task automatic run(input int n, input logic [31:0] w, input string req);
    for (int i = 0; i < n; i++) cyc(w, req);
  endtask

  task automatic wait_en(input logic [31:0] w, input string req);
    int guard = 0;
    while (!pix_en && guard < 3000) begin cyc(w, req); guard++; end
  endtask

  initial begin
    logic [31:0] w36;
    logic [31:0] w3;
    // R8: outputs held low in reset
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(!pix_en && !pix_clk, "R8 reset outputs", int'(pix_en | pix_clk), 0);
    end
    // Release: first edge samples divisor 5 (code 3)
    @(negedge clk);
    rst_n = 1'b1;
    cfg_word = 32'h0000_0003;
    model_step(cfg_word);
    since_en = 0;
    wait_en(32'h3, "R8");
    cyc(32'h3, "R8");
    check(last_gap == 5, "R8 first enable after full period", last_gap, 5);
    run(30, 32'h3, "R6");
    check(last_gap == 5, "R1 gap div5", last_gap, 5);
    check(last_hi == 2, "R6 odd high phase", last_hi, 2);

    // Divisor 2 (code 0)
    run(20, 32'h0, "R1");
    check(last_gap == 2, "R1 gap div2", last_gap, 2);
    check(last_hi == 1, "R6 div2 high phase", last_hi, 1);

    // High field used: hi=1 lo=2 -> code 34 -> divisor 36
    w36 = 32'h0800_0002;
    run(120, w36, "R1");
    check(last_gap == 36, "R1 split code gap", last_gap, 36);
    check(last_hi == 18, "R6 even high phase", last_hi, 18);

    // Noise in bits [25:5]
    run(120, w36 | 32'h03ff_ffe0, "R3");
    check(last_gap == 36, "R3 noise bits ignored gap", last_gap, 36);
    check(last_hi == 18, "R3 noise bits ignored clock", last_hi, 18);

    // Bypass with junk code fields
    run(20, 32'hfc00_001f, "R2");
    check(last_gap == 1, "R2 bypass gap", last_gap, 1);
    check(pix_en == 1'b1, "R2 bypass enable high", int'(pix_en), 1);
    check(pix_clk == 1'b0, "R7 bypass clock low", int'(pix_clk), 0);

    // Mid-period change from 36 to 3
    w3 = 32'h0000_0001;
    run(80, w36, "R4");
    wait_en(w36, "R4");
    run(6, w36, "R4");
    cyc(w3, "R4");
    wait_en(w3, "R4");
    cyc(w3, "R4");
    check(last_gap == 36, "R4 old period completes", last_gap, 36);
    wait_en(w3, "R4");
    cyc(w3, "R4");
    check(last_gap == 3, "R4 new divisor next period", last_gap, 3);
    run(12, w3, "R6");
    check(last_hi == 1, "R6 div3 high phase", last_hi, 1);

    // Largest divisor
    run(2200, 32'hf800_001f, "R5");
    check(last_gap == 1025, "R5 max divisor gap", last_gap, 1025);
    check(last_hi == 512, "R5 max divisor high phase", last_hi, 512);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule